// File: doc/BRIEF.md
# Interleaved AES-128 Round-Key Expander

This block produces AES-128 round keys on the fly for several independent cipher keys at once. Each key lives in a context that circulates through a ring of registers. There is one ring stage per slot of the shared round engine. Every cycle, one context sits at the head of the ring, and its current round key, slot index and round number appear on the outputs. The head slot advances by one every cycle, so a round engine with the same number of stages finds the key for the slot that is entering its key-addition step.

A context is written with a fresh cipher key from the load port. The context then shows that key as round 0. When the slot is at the head and its advance bit is high, the context leaves the head and derives the next round key. It does this from its own previous round key and its own round-constant index. The new key is visible when the slot next reaches the head. An option parameter places a register between the byte substitution and the word-chaining XORs, so the work is spread over two ring stages.

Top module: `aes_kexp_ring`

## Requirements
- R1: While reset is held, the outputs show slot 0, round 0 and an all-zero key. After reset, every context holds the all-zero key at round 0 until it is loaded or advanced.
- R2: The output slot index increases by one every clock and wraps from NUM_SLOTS-1 to 0. The index is k mod NUM_SLOTS in the k-th cycle after reset is released.
- R3: A cycle with `ld_vld_i` high writes `ld_key_i` into the context named by `ld_slot_i`, at round 0. That slot's next appearance at the outputs shows the loaded key with round 0. This is the following cycle when that slot is due next. Contexts of other slots are unchanged.
- R4: An advance needs two conditions in the same cycle: bit s of `adv_i` is high, and slot s is at the outputs with a round below 10. The next appearance of slot s then shows round+1 and the key derived from the one shown. Advance bits of the slots that are not at the outputs have no effect.
- R5: The round key is words w0..w3, with w0 in bits 127:96 and the first byte in bits 127:120. The next w0 is w0 XOR SubWord(RotWord(w3)) XOR {rcon,24'h0}. RotWord moves the top byte to the bottom. Each following word is its old value XOR the new word before it.
- R6: The round constant used to go from round r to r+1 is 01 doubled r times in GF(2^8) with the reduction constant 1B. This gives 01,02,04,08,10,20,40,80,1B,36. Each slot uses only its own round index.
- R7: A context at round 10 ignores further advances. It keeps showing the same key at round 10 until it is reloaded. The round output never exceeds 10.
- R8: When a load and an advance hit the same slot in the same cycle, the load wins. The slot next shows the loaded key at round 0.
- R9: Load key 2b7e151628aed2a6abf7158809cf4f3c and advance it ten times. Round 1 is then a0fafe1788542cb123a339392a6c7605, and round 10 is d014f9a8c9ee2589e13f0cc8b6630ca6.
- R10: Under arbitrary interleaved loads and advances on all slots, every slot's output sequence matches that slot's own independent expansion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ld_vld_i | input | 1 | Load strobe for one context |
| ld_slot_i | input | SLOT_W | Slot index written by a load |
| ld_key_i | input | 128 | Cipher key written by a load |
| adv_i | input | NUM_SLOTS | Per-slot advance request, honoured for the head slot only |
| rk_o | output | 128 | Round key of the head slot |
| rk_slot_o | output | SLOT_W | Slot index at the head |
| rk_rnd_o | output | 4 | Round number of the key on rk_o |

## Verification
A corrupted context has no error flag, so it shows up only as a wrong key, a wrong round number or a wrong slot index. This happens at that slot's next visit to the head, at most NUM_SLOTS cycles after the fault. A faulty derivation step stays in the context and is reused by every later round of that slot, so the error grows until the slot is reloaded. A mistake in ring rotation or in load steering shows within one cycle as a slot index out of sequence, or as another slot's key appearing.

// File: rtl/kx_pkg.sv
package kx_pkg;

   localparam int KEY_W    = 128;
   localparam int WORD_W   = 32;
   localparam int RND_W    = 4;
   localparam int LAST_RND = 10;

   // one key context as it travels round the ring
   typedef struct packed {
      logic [KEY_W-1:0]  key;   // current round key
      logic [RND_W-1:0]  rnd;   // round index of key
      logic [WORD_W-1:0] tw;    // registered transformed word (split variant)
      logic              pend;  // tw waits to be chained into key
   } kx_ctx_t;

   function automatic logic [7:0] gf_dbl(input logic [7:0] a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc;
      logic [7:0] sh;
      acc = 8'h00;
      sh  = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = gf_dbl(sh);
      end
      return acc;
   endfunction

   // a^254 = a^2 * a^4 * ... * a^128, zero maps to zero
   function automatic logic [7:0] gf_inv(input logic [7:0] a);
      logic [7:0] sq;
      logic [7:0] prod;
      sq   = a;
      prod = 8'h01;
      for (int i = 1; i < 8; i++) begin
         sq   = gf_mul(sq, sq);
         prod = gf_mul(prod, sq);
      end
      return prod;
   endfunction

   function automatic logic [7:0] sbox(input logic [7:0] a);
      logic [7:0] v;
      v = gf_inv(a);
      return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
               ^ {v[3:0], v[7:4]} ^ 8'h63;
   endfunction

   function automatic logic [WORD_W-1:0] rot_word(input logic [WORD_W-1:0] w);
      return {w[WORD_W-9:0], w[WORD_W-1 -: 8]};
   endfunction

   // constant for the step out of round r: 01 doubled r times
   function automatic logic [7:0] rcon_of(input logic [RND_W-1:0] r);
      logic [7:0] c;
      c = 8'h01;
      for (int i = 0; i < LAST_RND; i++) begin
         if (RND_W'(i) < r) c = gf_dbl(c);
      end
      return c;
   endfunction

endpackage

// File: rtl/kx_subword.sv
module kx_subword
   import kx_pkg::*;
#(
   parameter int BYTES = 4
) (
   input  logic [8*BYTES-1:0] w_i,
   output logic [8*BYTES-1:0] w_o
);

   if (BYTES < 1) begin : g_bad_bytes
      $error("kx_subword: BYTES must be at least 1");
   end

   for (genvar b = 0; b < BYTES; b++) begin : g_byte
      assign w_o[8*b +: 8] = sbox(w_i[8*b +: 8]);
   end

endmodule

// File: rtl/kx_mix.sv
module kx_mix
   import kx_pkg::*;
#(
   parameter int WORDS = KEY_W / WORD_W
) (
   input  logic [WORDS*WORD_W-1:0] key_i,
   input  logic [WORD_W-1:0]       tw_i,
   output logic [WORDS*WORD_W-1:0] key_o
);

   localparam int TOP = WORDS * WORD_W;

   logic [WORD_W-1:0] chain [WORDS+1];

   assign chain[0] = tw_i;

   // word 0 sits at the top; each new word feeds the next one down
   for (genvar w = 0; w < WORDS; w++) begin : g_word
      localparam int HI = TOP - 1 - w * WORD_W;
      assign chain[w+1]           = key_i[HI -: WORD_W] ^ chain[w];
      assign key_o[HI -: WORD_W]  = chain[w+1];
   end

endmodule

// File: rtl/kx_stage.sv
module kx_stage
   import kx_pkg::*;
#(
   parameter int SLOT_W = 2,
   parameter int RST_ID = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  kx_ctx_t           nxt_i,
   input  logic [SLOT_W-1:0] id_i,
   input  logic              ld_vld_i,
   input  logic [SLOT_W-1:0] ld_slot_i,
   input  logic [KEY_W-1:0]  ld_key_i,
   output kx_ctx_t           ctx_o,
   output logic [SLOT_W-1:0] id_o
);

   logic hit;

   assign hit = ld_vld_i && (ld_slot_i == id_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctx_o <= '0;
         id_o  <= SLOT_W'(RST_ID);
      end else begin
         id_o <= id_i;
         if (hit) begin
            ctx_o.key  <= ld_key_i;
            ctx_o.rnd  <= '0;
            ctx_o.tw   <= '0;
            ctx_o.pend <= 1'b0;
         end else begin
            ctx_o <= nxt_i;
         end
      end
   end

   // a load overrides any round step in flight for that context
   assert_load_lands_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit |=> (ctx_o.key == $past(ld_key_i)) && (ctx_o.rnd == '0) && !ctx_o.pend);

   assert_id_follows_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> id_o == $past(id_i));

endmodule

// File: rtl/aes_kexp_ring.sv
module aes_kexp_ring
   import kx_pkg::*;
#(
   parameter int NUM_SLOTS  = 4,
   parameter int SLOT_W     = $clog2(NUM_SLOTS),
   parameter bit SPLIT_SBOX = 1'b1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 ld_vld_i,
   input  logic [SLOT_W-1:0]    ld_slot_i,
   input  logic [KEY_W-1:0]     ld_key_i,
   input  logic [NUM_SLOTS-1:0] adv_i,
   output logic [KEY_W-1:0]     rk_o,
   output logic [SLOT_W-1:0]    rk_slot_o,
   output logic [RND_W-1:0]     rk_rnd_o
);

   localparam int DONE_IDX = 2 % NUM_SLOTS;   // stage that finishes a split step

   // elaboration checks
   if (NUM_SLOTS < 2) begin : g_bad_slots
      $error("aes_kexp_ring: NUM_SLOTS must be at least 2");
   end
   if ((1 << SLOT_W) != NUM_SLOTS) begin : g_bad_pow2
      $error("aes_kexp_ring: NUM_SLOTS must be a power of two matching SLOT_W");
   end
   if (NUM_SLOTS > 64) begin : g_bad_big
      $error("aes_kexp_ring: NUM_SLOTS larger than 64 not supported");
   end

   kx_ctx_t           ctx_q [NUM_SLOTS];
   logic [SLOT_W-1:0] id_q  [NUM_SLOTS];

   logic              adv_go;
   logic              hit_head;
   logic [WORD_W-1:0] sub_w;
   logic [WORD_W-1:0] tword_w;
   logic [KEY_W-1:0]  mix_key_in;
   logic [WORD_W-1:0] mix_tw_in;
   logic [KEY_W-1:0]  mix_key_out;

   assign adv_go   = adv_i[id_q[0]] && (ctx_q[0].rnd < RND_W'(LAST_RND));
   assign hit_head = ld_vld_i && (ld_slot_i == id_q[0]);

   // transformed last word of the head context
   kx_subword #(.BYTES(WORD_W / 8)) sub_i (
      .w_i (rot_word(ctx_q[0].key[WORD_W-1:0])),
      .w_o (sub_w)
   );

   assign tword_w = sub_w ^ {rcon_of(ctx_q[0].rnd), {(WORD_W-8){1'b0}}};

   // chaining XORs work on the head (single step) or on stage 1 (split step)
   if (SPLIT_SBOX) begin : g_mix_split
      assign mix_key_in = ctx_q[1].key;
      assign mix_tw_in  = ctx_q[1].tw;
   end else begin : g_mix_direct
      assign mix_key_in = ctx_q[0].key;
      assign mix_tw_in  = tword_w;
   end

   kx_mix #(.WORDS(KEY_W / WORD_W)) mix_i (
      .key_i (mix_key_in),
      .tw_i  (mix_tw_in),
      .key_o (mix_key_out)
   );

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_ring
      localparam int PRV = (i + NUM_SLOTS - 1) % NUM_SLOTS;
      localparam int RID = (NUM_SLOTS - i) % NUM_SLOTS;

      kx_ctx_t nxt;

      if (i == 1 && SPLIT_SBOX) begin : g_entry_split
         always_comb begin
            nxt = ctx_q[0];
            if (adv_go) begin
               nxt.tw   = tword_w;
               nxt.pend = 1'b1;
            end
         end
      end else if (i == 1) begin : g_entry_direct
         always_comb begin
            nxt = ctx_q[0];
            if (adv_go) begin
               nxt.key  = mix_key_out;
               nxt.rnd  = ctx_q[0].rnd + RND_W'(1);
               nxt.tw   = '0;
               nxt.pend = 1'b0;
            end
         end
      end else if (SPLIT_SBOX && i == DONE_IDX) begin : g_finish
         always_comb begin
            nxt = ctx_q[PRV];
            if (ctx_q[PRV].pend) begin
               nxt.key  = mix_key_out;
               nxt.rnd  = ctx_q[PRV].rnd + RND_W'(1);
               nxt.tw   = '0;
               nxt.pend = 1'b0;
            end
         end
      end else begin : g_pass
         assign nxt = ctx_q[PRV];
      end

      kx_stage #(.SLOT_W(SLOT_W), .RST_ID(RID)) stage_i (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .nxt_i     (nxt),
         .id_i      (id_q[PRV]),
         .ld_vld_i  (ld_vld_i),
         .ld_slot_i (ld_slot_i),
         .ld_key_i  (ld_key_i),
         .ctx_o     (ctx_q[i]),
         .id_o      (id_q[i])
      );
   end

   assign rk_o      = ctx_q[0].key;
   assign rk_slot_o = id_q[0];
   assign rk_rnd_o  = ctx_q[0].rnd;

   // ---------------- assertions ----------------
   assert_slot_rotates_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> int'(rk_slot_o) == ((int'($past(rk_slot_o)) + 1) % NUM_SLOTS));

   assert_idle_holds_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!adv_go && !hit_head) |=> ctx_q[1] == $past(ctx_q[0]));

   if (SPLIT_SBOX) begin : g_chk_split
      assert_step_starts_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         (adv_go && !hit_head) |=> ctx_q[1].pend && (ctx_q[1].rnd == $past(rk_rnd_o))
                                   && (ctx_q[1].key == $past(rk_o)));
   end else begin : g_chk_direct
      assert_step_starts_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         (adv_go && !hit_head) |=> ctx_q[1].rnd == $past(rk_rnd_o) + RND_W'(1));
   end

   assert_head_settled_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctx_q[0].pend);

   assert_round_cap_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      rk_rnd_o <= RND_W'(LAST_RND));

   assert_final_sticks_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rk_rnd_o == RND_W'(LAST_RND) && !hit_head)
         |=> (ctx_q[1].key == $past(rk_o)) && (ctx_q[1].rnd == RND_W'(LAST_RND)));

endmodule

// File: tb/aes_kexp_ring_tb_top.sv
`timescale 1ns/1ps
module aes_kexp_ring_tb_top;

   localparam int N  = 4;
   localparam int SW = 2;

   logic           clk = 1'b0;
   logic           rst_ni;
   logic           ld_vld;
   logic [SW-1:0]  ld_slot;
   logic [127:0]   ld_key;
   logic [N-1:0]   adv;
   logic [127:0]   rk;
   logic [SW-1:0]  rk_slot;
   logic [3:0]     rk_rnd;

   always #2 clk = ~clk;   // 250 MHz

   aes_kexp_ring #(.NUM_SLOTS(N), .SLOT_W(SW)) dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_ni),
      .ld_vld_i  (ld_vld),
      .ld_slot_i (ld_slot),
      .ld_key_i  (ld_key),
      .adv_i     (adv),
      .rk_o      (rk),
      .rk_slot_o (rk_slot),
      .rk_rnd_o  (rk_rnd)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit fin   = 1'b0;

   // ---------------- reference expansion ----------------
   logic [7:0] sb [256];

   function automatic logic [7:0] bmul(input logic [7:0] x, input logic [7:0] y);
      logic [15:0] p;
      p = '0;
      for (int i = 0; i < 8; i++) if (y[i]) p = p ^ (16'(x) << i);
      for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
      return p[7:0];
   endfunction

   function automatic logic [7:0] rl(input logic [7:0] v, input int n);
      return (v << n) | (v >> (8 - n));
   endfunction

   function automatic logic [127:0] ref_rk(input logic [127:0] k0, input int n);
      logic [31:0] w [4];
      logic [31:0] t;
      logic [7:0]  rc;
      for (int i = 0; i < 4; i++) w[i] = k0[127 - 32*i -: 32];
      rc = 8'h01;
      for (int r = 0; r < n; r++) begin
         t = {sb[w[3][23:16]], sb[w[3][15:8]], sb[w[3][7:0]], sb[w[3][31:24]]};
         t[31:24] = t[31:24] ^ rc;
         w[0] = w[0] ^ t;
         w[1] = w[1] ^ w[0];
         w[2] = w[2] ^ w[1];
         w[3] = w[3] ^ w[2];
         rc = bmul(rc, 8'h02);
      end
      return {w[0], w[1], w[2], w[3]};
   endfunction

   // ---------------- scoreboard ----------------
   typedef struct {
      int           slot;
      int           rnd;
      logic [127:0] key;
      string        tag;
   } exp_t;

   exp_t         exp_q [$];
   exp_t         e;
   bit           mon_en = 1'b0;
   logic [127:0] m_key [N];
   int           m_rnd [N];
   int           cyc;

   task automatic chk128(input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exq);
      n_chk++;
      if (act !== exq) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exq);
      end
   endtask

   task automatic chki(input string tag, input string what, input int act, input int exq);
      n_chk++;
      if (act != exq) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exq);
      end
   endtask

   always @(negedge clk) begin
      if (mon_en && exp_q.size() > 0) begin
         e = exp_q.pop_front();
         chki("R2", "slot", int'(rk_slot), e.slot);
         chki(e.tag, "round", int'(rk_rnd), e.rnd);
         chk128(e.tag, "key", rk, e.key);
      end
   end

   // driver: one call per cycle, entered just after a falling edge
   task automatic step(input bit ld, input int ls, input logic [127:0] lk,
                       input logic [N-1:0] av, input string tag);
      int cur;
      int nx;
      exp_t it;
      cur     = cyc % N;
      ld_vld  = ld;
      ld_slot = SW'(ls);
      ld_key  = lk;
      adv     = av;
      if (av[cur] && !(ld && ls == cur) && m_rnd[cur] < 10) m_rnd[cur]++;
      if (ld) begin
         m_key[ls] = lk;
         m_rnd[ls] = 0;
      end
      nx      = (cyc + 1) % N;
      it.slot = nx;
      it.rnd  = m_rnd[nx];
      it.key  = ref_rk(m_key[nx], m_rnd[nx]);
      it.tag  = tag;
      exp_q.push_back(it);
      cyc++;
      @(negedge clk);
      #1;
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, 0, '0, '0, tag);
   endtask

   localparam logic [127:0] FIPS_K  = 128'h2b7e151628aed2a6abf7158809cf4f3c;
   localparam logic [127:0] FIPS_R1 = 128'ha0fafe1788542cb123a339392a6c7605;
   localparam logic [127:0] FIPS_RA = 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;

   initial begin
      for (int b = 0; b < 256; b++) begin
         logic [7:0] inv;
         inv = 8'h00;
         for (int c = 1; c < 256; c++) if (bmul(8'(b), 8'(c)) == 8'h01) inv = 8'(c);
         sb[b] = inv ^ rl(inv, 1) ^ rl(inv, 2) ^ rl(inv, 3) ^ rl(inv, 4) ^ 8'h63;
      end
      for (int s = 0; s < N; s++) begin
         m_key[s] = '0;
         m_rnd[s] = 0;
      end
      cyc     = 0;
      rst_ni  = 1'b0;
      ld_vld  = 1'b0;
      ld_slot = '0;
      ld_key  = '0;
      adv     = '0;

      // R1: state under reset
      repeat (3) @(negedge clk);
      chki("R1", "reset slot", int'(rk_slot), 0);
      chki("R1", "reset round", int'(rk_rnd), 0);
      chk128("R1", "reset key", rk, '0);
      #1;
      rst_ni = 1'b1;
      mon_en = 1'b1;
      idle(2 * N, "R1");

      // R3: loads into every slot, including the slot due next
      step(1'b1, (cyc + 1) % N, 128'h00112233445566778899aabbccddeeff, '0, "R3");
      step(1'b1, 3, 128'hffeeddccbbaa99887766554433221100, '0, "R3");
      step(1'b1, 0, 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0, '0, "R3");
      step(1'b1, 2, 128'h13579bdf2468ace0fdb97531eca86420, '0, "R3");
      idle(2 * N, "R3");

      // R4: advance bits of non-head slots only, then all bits
      for (int i = 0; i < 2 * N; i++) step(1'b0, 0, '0, ~(N'(1) << (cyc % N)), "R4");
      for (int i = 0; i < 2 * N; i++) step(1'b0, 0, '0, '1, "R4");
      idle(N, "R4");

      // R5 / R9: published vector in slot 2
      step(1'b1, 2, FIPS_K, '0, "R5");
      for (int i = 0; i < 4 * N && !(rk_slot == 2 && rk_rnd == 1); i++)
         step(1'b0, 0, '0, N'(4), "R5");
      chk128("R5", "round 1 of published key", rk, FIPS_R1);
      for (int i = 0; i < 12 * N && !(rk_slot == 2 && rk_rnd == 10); i++)
         step(1'b0, 0, '0, N'(4), "R9");
      chk128("R9", "round 10 of published key", rk, FIPS_RA);
      chki("R9", "final round number", int'(rk_rnd), 10);

      // R6: slots advancing at different rates use their own constants
      step(1'b1, 0, 128'hdeadbeef0123456789abcdeffedcba98, '0, "R6");
      step(1'b1, 1, 128'h0000000000000000000000000000ffff, '0, "R6");
      for (int i = 0; i < 15 * N; i++)
         step(1'b0, 0, '0, {1'b0, 1'b0, ((cyc / N) % 2 == 0), 1'b1}, "R6");

      // R7: everything runs to the final round and stays there
      for (int i = 0; i < 14 * N; i++) step(1'b0, 0, '0, '1, "R7");
      idle(N, "R7");

      // R8: load and advance of the head slot in the same cycle
      for (int i = 0; i < 2 * N; i++)
         step(1'b1, cyc % N, {4{32'(cyc) ^ 32'h5a5a1234}}, '1, "R8");
      idle(N, "R8");

      // R10: random interleaved traffic
      for (int i = 0; i < 400; i++) begin
         bit ld;
         ld = ($urandom % 6) == 0;
         step(ld, $urandom % N, {$urandom, $urandom, $urandom, $urandom},
              N'($urandom), "R10");
      end
      idle(N, "R10");

      fin = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!fin) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule